// File: doc/BRIEF.md
# Chained Descriptor Transfer Engine

This block moves data between locations of a synchronous memory on behalf of peripheral events or software. Each transfer job is described by a descriptor kept in an internal table. A descriptor holds a 32-bit source address, a 32-bit destination address, a transfer count and a control word. The control word sets the unit size, the mode, how each address steps, and whether the job links on to the next descriptor. Software fills the table through a small write/read register port. A job is started either by one of eight hardware request lines, each mapped to a descriptor of its choice, or by a software trigger write.

One activation runs one descriptor, or a linked series of them, and then gives a single-cycle done pulse. The mode sets what one activation does. In normal mode one unit moves and the count drops by one. In repeat mode one unit moves and, when the count runs out, the count and one chosen address return to their start values. In block mode a whole block of units moves and the count of blocks drops by one. Updated addresses and counts are written back to the table, so the next activation continues from where the last one stopped.

Top module: `dtc_engine`

## Requirements
- R1: After reset `busy`, `done` and `mem_req` are low, and `mem_req` is never high while `busy` is low.
- R2: Control bits [1:0] select the unit size: 0 is byte, 1 is 16-bit word, 2 is 32-bit longword. `mem_size` carries this code, and an incrementing address steps by 1, 2 or 4.
- R3: Control bit 4 (source) and bit 5 (destination) make the address increment when 1. When the bit is 0 the address stays fixed for every unit.
- R4: Normal mode (control bits [3:2] = 0) moves one unit per activation as a read followed by a write, and writes back the count minus one. A normal or block descriptor whose count is 0 makes no memory access.
- R5: In repeat mode (bits [3:2] = 1), when the count reaches zero it reloads to its configured start value. The address chosen by bit 7 (1 = source, 0 = destination) also reloads to its configured start value, and the other address keeps its stepped value.
- R6: Block mode (bits [3:2] = 2) moves bits [15:8] units in one activation and then lowers the count by one.
- R7: With bit 6 (chain) set, the activation goes on to the descriptor whose index is one higher, and the whole series gives one done pulse.
- R8: A configuration write to field 5 starts the descriptor named by `cfg_desc`. Fields 0 to 3 are source, destination, count and control, and they read back on `cfg_rdata` one cycle after `cfg_desc`/`cfg_field` are presented while idle. Field 4 makes request line `cfg_wdata[2:0]` start descriptor `cfg_desc`.
- R9: Among pending hardware requests the lowest-numbered one is served first. Requests that pulse while the engine is busy are kept and served later.
- R10: `done` is high for exactly one cycle after the last descriptor of an activation finishes, and only while the engine is idle.
- R11: Writes to descriptor fields 0 to 4 are ignored while `busy` is high.
- R12: Source and destination addresses are full 32-bit values, carried unchanged to `mem_addr` and written back after stepping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_desc | input | 4 | Descriptor index for configuration write/read/trigger |
| cfg_field | input | 3 | Field select: 0 src, 1 dst, 2 count, 3 control, 4 request map, 5 trigger |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read-back of the selected descriptor field |
| hw_req | input | 8 | Hardware request pulses, one per line |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory access is a write |
| mem_size | output | 2 | Unit size of the access |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read strobe |
| busy | output | 1 | Engine is running an activation |
| done | output | 1 | One-cycle completion pulse |

## Verification
A table of descriptors covers each unit size with incrementing, fixed and mixed address steps in both normal and block mode. The fixed cases show whether the step control is honoured apart from the size, and a high-order address shows that all 32 bits are carried. Repeat mode is run once with the source area reloading and once with the destination area reloading. This shows that only the chosen address returns to its start value. Two requests pulsed together during a busy software job, plus a descriptor write issued at the same time, test ordering, request latching and the write lockout. A two-link chain and a zero-count descriptor test the single done pulse and the no-access case.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

  localparam logic [2:0] F_SRC  = 3'd0;
  localparam logic [2:0] F_DST  = 3'd1;
  localparam logic [2:0] F_CNT  = 3'd2;
  localparam logic [2:0] F_CTRL = 3'd3;
  localparam logic [2:0] F_MAP  = 3'd4;
  localparam logic [2:0] F_TRIG = 3'd5;

  localparam logic [1:0] M_NORMAL = 2'd0;
  localparam logic [1:0] M_REPEAT = 2'd1;
  localparam logic [1:0] M_BLOCK  = 2'd2;

  typedef struct packed {
    logic [7:0] blk;
    logic       rpt_src;
    logic       chain;
    logic       dst_inc;
    logic       src_inc;
    logic [1:0] mode;
    logic [1:0] size;
  } ctrl_t;

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_LATCH, S_RD, S_CAP, S_WR, S_FIN
  } eng_st_e;

endpackage

// File: rtl/dtc_ram.sv
module dtc_ram #(
  parameter int W = 32,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dtc_req_arb.sv
module dtc_req_arb #(
  parameter int NREQ = 8,
  parameter int NDESC = 16,
  localparam int RW = $clog2(NREQ),
  localparam int DW = $clog2(NDESC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREQ-1:0] hw_req,
  input  logic            map_we,
  input  logic [RW-1:0]   map_req,
  input  logic [DW-1:0]   map_desc,
  input  logic            sw_we,
  input  logic [DW-1:0]   sw_desc,
  input  logic            eng_idle,
  output logic            start,
  output logic [DW-1:0]   start_desc
);
  logic [NREQ-1:0] pend;
  logic [NREQ-1:0] clr_vec;
  logic [DW-1:0]   map_q [NREQ];
  logic            sw_pend;
  logic [DW-1:0]   sw_q;
  logic            hit;
  logic [RW-1:0]   gi;

  for (genvar g = 0; g < NREQ; g++) begin : g_map
    always_ff @(posedge clk) begin
      if (rst) map_q[g] <= DW'(g);
      else if (map_we && map_req == RW'(g)) map_q[g] <= map_desc;
    end
  end

  always_comb begin
    hit = 1'b0;
    gi  = '0;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (pend[i]) begin
        hit = 1'b1;
        gi  = RW'(i);
      end
    end
    for (int i = 0; i < NREQ; i++) clr_vec[i] = eng_idle && hit && (gi == RW'(i));
  end

  assign start      = eng_idle && (hit || sw_pend);
  assign start_desc = hit ? map_q[gi] : sw_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= '0;
      sw_pend <= 1'b0;
      sw_q    <= '0;
    end else begin
      pend <= (pend & ~clr_vec) | hw_req;
      if (sw_we) begin
        sw_pend <= 1'b1;
        sw_q    <= sw_desc;
      end else if (eng_idle && !hit && sw_pend) begin
        sw_pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dtc_xfer_eng.sv
module dtc_xfer_eng
  import dtc_pkg::*;
#(
  parameter int NDESC = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W = 16,
  localparam int DW = $clog2(NDESC),
  localparam int UW = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DW-1:0]     start_desc,
  input  logic [ADDR_W-1:0] d_src,
  input  logic [ADDR_W-1:0] d_dst,
  input  logic [CNT_W-1:0]  d_cnt,
  input  logic [ADDR_W-1:0] d_src0,
  input  logic [ADDR_W-1:0] d_dst0,
  input  logic [CNT_W-1:0]  d_cnt0,
  input  ctrl_t             d_ctrl,
  output logic [DW-1:0]     cur_desc,
  output logic              idle,
  output logic              wb_we,
  output logic [ADDR_W-1:0] wb_src,
  output logic [ADDR_W-1:0] wb_dst,
  output logic [CNT_W-1:0]  wb_cnt,
  output logic              mem_req,
  output logic              mem_we,
  output logic [1:0]        mem_size,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done
);
  localparam logic [DW-1:0] ONE_D = DW'(1);

  eng_st_e           st;
  logic [DW-1:0]     idx;
  logic [ADDR_W-1:0] src, dst, src0, dst0;
  logic [CNT_W-1:0]  cnt, cnt0;
  ctrl_t             ctrl;
  logic [UW-1:0]     units;
  logic [DATA_W-1:0] data_q;
  logic              skip;
  logic              done_q;
  logic [ADDR_W-1:0] step, src_step, dst_step;
  logic [CNT_W-1:0]  cnt_dec;
  logic              wrap;

  assign step     = {{(ADDR_W-3){1'b0}}, 3'b001} << ctrl.size;
  assign src_step = ctrl.src_inc ? step : '0;
  assign dst_step = ctrl.dst_inc ? step : '0;
  assign cnt_dec  = cnt - CNT_W'(1);
  assign wrap     = (ctrl.mode == M_REPEAT) && (cnt_dec == '0);

  always_comb begin
    wb_cnt = wrap ? cnt0 : cnt_dec;
    wb_src = (wrap && ctrl.rpt_src) ? src0 : src;
    wb_dst = (wrap && !ctrl.rpt_src) ? dst0 : dst;
  end

  assign wb_we     = (st == S_FIN) && !skip;
  assign cur_desc  = idx;
  assign idle      = (st == S_IDLE);
  assign mem_req   = (st == S_RD) || (st == S_WR);
  assign mem_we    = (st == S_WR);
  assign mem_size  = ctrl.size;
  assign mem_addr  = (st == S_WR) ? dst : src;
  assign mem_wdata = data_q;
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      idx    <= '0;
      done_q <= 1'b0;
      ctrl   <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          idx <= start_desc;
          st  <= S_LOAD;
        end
        S_LOAD: st <= S_LATCH;
        S_LATCH: begin
          src   <= d_src;
          dst   <= d_dst;
          cnt   <= d_cnt;
          src0  <= d_src0;
          dst0  <= d_dst0;
          cnt0  <= d_cnt0;
          ctrl  <= d_ctrl;
          units <= (d_ctrl.mode == M_BLOCK) ? {1'b0, d_ctrl.blk} : UW'(1);
          skip  <= (d_cnt == '0) && (d_ctrl.mode != M_REPEAT);
          st    <= ((d_cnt == '0) && (d_ctrl.mode != M_REPEAT)) ? S_FIN : S_RD;
        end
        S_RD: st <= S_CAP;
        S_CAP: begin
          data_q <= mem_rdata;
          st     <= S_WR;
        end
        S_WR: begin
          src <= src + src_step;
          dst <= dst + dst_step;
          if (units <= UW'(1)) begin
            st <= S_FIN;
          end else begin
            units <= units - UW'(1);
            st    <= S_RD;
          end
        end
        S_FIN: if (ctrl.chain) begin
          idx <= idx + ONE_D;
          st  <= S_LOAD;
        end else begin
          st     <= S_IDLE;
          done_q <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dtc_engine.sv
module dtc_engine
  import dtc_pkg::*;
#(
  parameter int NREQ = 8,
  parameter int NDESC = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W = 16,
  localparam int DW = $clog2(NDESC),
  localparam int RW = $clog2(NREQ),
  localparam int CTRL_W = $bits(ctrl_t)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [DW-1:0]     cfg_desc,
  input  logic [2:0]        cfg_field,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic [NREQ-1:0]   hw_req,
  output logic              mem_req,
  output logic              mem_we,
  output logic [1:0]        mem_size,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done
);
  logic              idle, start, wb_we;
  logic [DW-1:0]     start_desc, eng_desc, raddr, waddr;
  logic [ADDR_W-1:0] q_src, q_dst, q_src0, q_dst0, wb_src, wb_dst;
  logic [CNT_W-1:0]  q_cnt, q_cnt0, wb_cnt;
  logic [CTRL_W-1:0] q_ctrl;
  logic              cfg_ok;
  logic [2:0]        field_q;

  assign cfg_ok = cfg_we && idle;
  assign raddr  = idle ? cfg_desc : eng_desc;
  assign waddr  = wb_we ? eng_desc : cfg_desc;
  assign busy   = !idle;

  dtc_ram #(.W(ADDR_W), .DEPTH(NDESC)) u_src (
    .clk, .we(wb_we || (cfg_ok && cfg_field == F_SRC)), .waddr,
    .wdata(wb_we ? wb_src : cfg_wdata), .raddr, .rdata(q_src));
  dtc_ram #(.W(ADDR_W), .DEPTH(NDESC)) u_dst (
    .clk, .we(wb_we || (cfg_ok && cfg_field == F_DST)), .waddr,
    .wdata(wb_we ? wb_dst : cfg_wdata), .raddr, .rdata(q_dst));
  dtc_ram #(.W(CNT_W), .DEPTH(NDESC)) u_cnt (
    .clk, .we(wb_we || (cfg_ok && cfg_field == F_CNT)), .waddr,
    .wdata(wb_we ? wb_cnt : cfg_wdata[CNT_W-1:0]), .raddr, .rdata(q_cnt));
  dtc_ram #(.W(ADDR_W), .DEPTH(NDESC)) u_src0 (
    .clk, .we(cfg_ok && cfg_field == F_SRC), .waddr(cfg_desc),
    .wdata(cfg_wdata), .raddr, .rdata(q_src0));
  dtc_ram #(.W(ADDR_W), .DEPTH(NDESC)) u_dst0 (
    .clk, .we(cfg_ok && cfg_field == F_DST), .waddr(cfg_desc),
    .wdata(cfg_wdata), .raddr, .rdata(q_dst0));
  dtc_ram #(.W(CNT_W), .DEPTH(NDESC)) u_cnt0 (
    .clk, .we(cfg_ok && cfg_field == F_CNT), .waddr(cfg_desc),
    .wdata(cfg_wdata[CNT_W-1:0]), .raddr, .rdata(q_cnt0));
  dtc_ram #(.W(CTRL_W), .DEPTH(NDESC)) u_ctrl (
    .clk, .we(cfg_ok && cfg_field == F_CTRL), .waddr(cfg_desc),
    .wdata(cfg_wdata[CTRL_W-1:0]), .raddr, .rdata(q_ctrl));

  always_ff @(posedge clk) begin
    if (rst) field_q <= F_SRC;
    else     field_q <= cfg_field;
  end

  always_comb begin
    case (field_q)
      F_SRC:   cfg_rdata = q_src;
      F_DST:   cfg_rdata = q_dst;
      F_CNT:   cfg_rdata = {{(ADDR_W-CNT_W){1'b0}}, q_cnt};
      F_CTRL:  cfg_rdata = {{(ADDR_W-CTRL_W){1'b0}}, q_ctrl};
      default: cfg_rdata = '0;
    endcase
  end

  dtc_req_arb #(.NREQ(NREQ), .NDESC(NDESC)) u_arb (
    .clk, .rst, .hw_req,
    .map_we(cfg_ok && cfg_field == F_MAP), .map_req(cfg_wdata[RW-1:0]),
    .map_desc(cfg_desc),
    .sw_we(cfg_we && cfg_field == F_TRIG), .sw_desc(cfg_desc),
    .eng_idle(idle), .start, .start_desc);

  dtc_xfer_eng #(.NDESC(NDESC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_eng (
    .clk, .rst, .start, .start_desc,
    .d_src(q_src), .d_dst(q_dst), .d_cnt(q_cnt),
    .d_src0(q_src0), .d_dst0(q_dst0), .d_cnt0(q_cnt0), .d_ctrl(ctrl_t'(q_ctrl)),
    .cur_desc(eng_desc), .idle, .wb_we, .wb_src, .wb_dst, .wb_cnt,
    .mem_req, .mem_we, .mem_size, .mem_addr, .mem_wdata, .mem_rdata, .done);
endmodule

// File: rtl/dtc_chk.sv
module dtc_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done,
  input logic       mem_req,
  input logic       mem_we,
  input logic [1:0] mem_size
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);
  p_size_legal_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_size != 2'b11));
  p_read_then_write_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> ($past(busy) && !$past(mem_req)));
  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_when_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
endmodule

bind dtc_engine dtc_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size));

// File: tb/sim_dtc_engine.sv
module sim_dtc_engine;
  import dtc_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_desc = '0;
  logic [2:0]  cfg_field = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [7:0]  hw_req = '0;
  logic        mem_req, mem_we, busy, done;
  logic [1:0]  mem_size;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;

  int checks = 0, errors = 0, donecnt = 0, wcount = 0, wptr = 0;
  int run_len = 0, max_run = 0;
  bit finished = 0;
  logic [7:0]  mem [1024];
  logic [31:0] wlog [64];

  always #4 clk = ~clk;

  dtc_engine u0 (.*);

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 37 + 11);
  endfunction

  // memory model: responds at the falling edge
  always @(negedge clk) begin
    if (mem_req && !mem_we)
      for (int b = 0; b < 4; b++) mem_rdata[8*b +: 8] <= mem[(mem_addr + b) & 1023];
    if (mem_req && mem_we) begin
      for (int b = 0; b < (1 << mem_size); b++)
        mem[(mem_addr + b) & 1023] <= mem_wdata[8*b +: 8];
      wcount <= wcount + 1;
      if (wptr < 64) wlog[wptr] <= mem_addr;
      wptr <= wptr + 1;
    end
    if (done) begin
      donecnt <= donecnt + 1;
      run_len = run_len + 1;
      if (run_len > max_run) max_run = run_len;
    end else run_len = 0;
  end

  // {ctrl[15:0], src[31:0], dst[31:0], cnt[15:0]}
  localparam logic [95:0] VEC [7] = '{
    {16'h0030, 32'h0000_0010, 32'h0000_0200, 16'd5},
    {16'h0031, 32'h0000_0020, 32'h0000_0210, 16'd1},
    {16'h0032, 32'hABCD_0030, 32'h1234_0220, 16'd4},
    {16'h0439, 32'h0000_0040, 32'h0000_0230, 16'd3},
    {16'h031A, 32'h0000_0050, 32'h0000_0240, 16'd1},
    {16'h0228, 32'h0000_0060, 32'h0000_0250, 16'd7},
    {16'h0002, 32'hFFFF_FF80, 32'h0000_0260, 16'd9}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input int d, input logic [2:0] f, input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_desc = 4'(d); cfg_field = f; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input int d, input logic [2:0] f, output logic [31:0] v);
    @(negedge clk);
    cfg_desc = 4'(d); cfg_field = f;
    @(negedge clk);
    v = cfg_rdata;
  endtask

  task automatic load(input int d, input logic [15:0] c, input logic [31:0] s,
                      input logic [31:0] t, input logic [15:0] n);
    cfg_wr(d, F_CTRL, {16'h0, c});
    cfg_wr(d, F_SRC, s);
    cfg_wr(d, F_DST, t);
    cfg_wr(d, F_CNT, {16'h0, n});
  endtask

  task automatic wait_done(input int target);
    for (int k = 0; k < 600 && donecnt < target; k++) @(negedge clk);
    if (donecnt < target) chk("R8 activation completes", 32'(donecnt), 32'(target));
    @(negedge clk);
  endtask

  task automatic run(input int d);
    int base;
    base = donecnt;
    cfg_wr(d, F_TRIG, 32'h0);
    wait_done(base + 1);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [31:0] rb, act, exp, s, t, sa, da;
    logic [15:0] c, n;
    int units, bytes, base, w0;
    for (int i = 0; i < 1024; i++) mem[i] = pat(i);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy after reset", 32'(busy), 0);
    chk("R1 done after reset", 32'(done), 0);
    chk("R1 mem_req after reset", 32'(mem_req), 0);

    // table-driven single activations (R2 R3 R4 R6 R8 R12)
    for (int e = 0; e < 7; e++) begin
      c = VEC[e][95:80]; s = VEC[e][79:48]; t = VEC[e][47:16]; n = VEC[e][15:0];
      load(0, c, s, t, n);
      run(0);
      bytes = 1 << c[1:0];
      units = (c[3:2] == M_BLOCK) ? int'(c[15:8]) : 1;
      for (int u = 0; u < units; u++) begin
        if (c[5] || u == units - 1) begin
          sa = s + (c[4] ? 32'(u * bytes) : 0);
          da = t + (c[5] ? 32'(u * bytes) : 0);
          act = 0; exp = 0;
          for (int b = 0; b < bytes; b++) begin
            exp[8*b +: 8] = pat(int'((sa + b) & 1023));
            act[8*b +: 8] = mem[(da + b) & 1023];
          end
          chk(c[3:2] == M_BLOCK ? "R6 R2 R3 block data" : "R4 R2 R3 unit data", act, exp);
        end
      end
      cfg_rd(0, F_SRC, rb);
      chk("R2 R3 R12 source write-back", rb, s + (c[4] ? 32'(units * bytes) : 0));
      cfg_rd(0, F_DST, rb);
      chk("R2 R3 R12 destination write-back", rb, t + (c[5] ? 32'(units * bytes) : 0));
      cfg_rd(0, F_CNT, rb);
      chk(c[3:2] == M_BLOCK ? "R6 count write-back" : "R4 count write-back", rb, 32'(n - 1));
    end

    // R4: zero count makes no access
    load(1, 16'h0031, 32'h20, 32'h2A0, 16'd0);
    w0 = wcount;
    run(1);
    chk("R4 zero count writes", 32'(wcount), 32'(w0));
    chk("R4 zero count memory", 32'(mem[10'h2A0]), 32'(pat(32'h2A0)));

    // R5: repeat with source area, then destination area
    load(14, 16'h00B4, 32'hA0, 32'h280, 16'd2);
    run(14);
    run(14);
    cfg_rd(14, F_SRC, rb); chk("R5 source reloaded", rb, 32'hA0);
    cfg_rd(14, F_DST, rb); chk("R5 destination keeps stepping", rb, 32'h282);
    cfg_rd(14, F_CNT, rb); chk("R5 count reloaded", rb, 2);
    chk("R5 second unit data", 32'(mem[10'h281]), 32'(pat(32'hA1)));
    load(15, 16'h0034, 32'hB0, 32'h290, 16'd1);
    run(15);
    cfg_rd(15, F_SRC, rb); chk("R5 source keeps stepping", rb, 32'hB1);
    cfg_rd(15, F_DST, rb); chk("R5 destination reloaded", rb, 32'h290);

    // R7: two-link chain, single done
    load(12, 16'h0070, 32'h90, 32'h330, 16'd2);
    load(13, 16'h0030, 32'h91, 32'h331, 16'd2);
    base = donecnt;
    run(12);
    repeat (30) @(negedge clk);
    chk("R7 one done for chain", 32'(donecnt), 32'(base + 1));
    chk("R7 first link data", 32'(mem[10'h330]), 32'(pat(32'h90)));
    chk("R7 second link data", 32'(mem[10'h331]), 32'(pat(32'h91)));
    cfg_rd(13, F_CNT, rb); chk("R7 second link count", rb, 1);

    // R9 R11: requests during busy, priority, write lockout
    load(8, 16'h0032, 32'h70, 32'h300, 16'd10);
    load(9, 16'h0032, 32'h74, 32'h310, 16'd10);
    load(10, 16'h0032, 32'h78, 32'h320, 16'd10);
    cfg_wr(10, F_MAP, 32'd5);
    cfg_wr(9, F_MAP, 32'd2);
    wptr = 0;
    base = donecnt;
    cfg_wr(8, F_TRIG, 32'h0);
    @(negedge clk);
    hw_req = 8'b0010_0100;
    @(negedge clk);
    hw_req = 8'h00;
    chk("R11 engine busy during write", 32'(busy), 1);
    cfg_wr(8, F_SRC, 32'hDEAD);
    wait_done(base + 3);
    chk("R9 first write", wlog[0], 32'h300);
    chk("R9 lowest request next", wlog[1], 32'h310);
    chk("R9 latched request last", wlog[2], 32'h320);
    cfg_rd(8, F_SRC, rb); chk("R11 write while busy ignored", rb, 32'h74);
    cfg_rd(8, F_CNT, rb); chk("R4 count after hardware run", rb, 9);

    chk("R10 done width", 32'(max_run), 1);
    summary();
  end
endmodule